// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block loads a configuration image into a downstream programmable device over a slave-serial link. After a start request it turns on the device's supply enable, waits a settling time, pulses the active-low program line for a fixed time, and then waits for the device's active-low init line to go high. That wait is bounded. Once the device is ready, the loader accepts exactly the stated number of bytes on a valid/ready input. It shifts each byte out most significant bit first on a data line, with one clock pulse per bit.

After the last byte, the loader keeps pulsing the configuration clock until the device raises its done line. This wait is also bounded. The run ends in one of two ways: a success state, or an error state with a code that tells which wait expired. The byte source can flag an error during the data phase. The loader then stops taking data, lets the byte in flight finish, and moves straight to the done-wait phase.

Top module: `serial_cfg_loader`

## Requirements
- R1: Out of reset the loader is idle: prog_n=1, cclk=0, din=0, pwr_en=0, busy=ok=err=0 and in_ready=0.
- R2: A start in the idle, ok or error state raises pwr_en at once. prog_n stays high for SETTLE_CYCLES clocks, then goes low for exactly PROG_LOW_CYCLES clocks, then returns high. prog_n is never low without pwr_en, and cclk never rises while prog_n is low.
- R3: After prog_n is released, the loader waits for init_n=1. If init_n stays low for INIT_TIMEOUT clocks, the loader enters the error state with err_code=2'b01 and emits no cclk pulse.
- R4: Each byte is sent most significant bit first. din is valid at each rising edge of cclk and changes only while cclk is low.
- R5: Every cclk high phase lasts exactly HALF_CYCLES clocks. Every cclk low phase before a rising edge lasts at least HALF_CYCLES clocks.
- R6: Exactly byte_len bytes are accepted, each on a cycle where in_valid and in_ready are both high. in_ready is high only during the data phase, while the shifter is free and bytes remain.
- R7: Once the data phase ends, cclk keeps pulsing with din=0 until done_in is seen high between pulses. The loader then enters the ok state. The number of extra pulses equals the number of pulses the device needed, and is zero if done_in is already high.
- R8: If done_in stays low for DONE_TIMEOUT extra pulses, the loader enters the error state with err_code=2'b10.
- R9: If in_error is high during the data phase, the loader accepts no further bytes and finishes the byte in progress. It then proceeds to the done-wait phase of R7.
- R10: busy, ok and err are mutually exclusive. ok or err holds until the next start, and a start while busy has no effect. err_code is 2'b00 unless err is high.
- R11: With byte_len=0, no byte is accepted and the loader goes straight from the init wait to the done-wait phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| byte_len | input | LEN_W | Number of bytes to send, captured at start |
| in_data | input | 8 | Configuration byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Loader takes in_data this cycle if in_valid |
| in_error | input | 1 | Source-side error; ends the data phase |
| init_n | input | 1 | Device init line, high when ready for data |
| done_in | input | 1 | Device done line |
| pwr_en | output | 1 | Device supply enable |
| prog_n | output | 1 | Active-low program pulse to the device |
| cclk | output | 1 | Configuration clock |
| din | output | 1 | Configuration data bit |
| busy | output | 1 | Run in progress |
| ok | output | 1 | Last run finished with done seen |
| err | output | 1 | Last run timed out |
| err_code | output | 2 | 01 init timeout, 10 done timeout, 00 none |

## Verification
Byte streams of several lengths are tried: three mixed bytes, a single byte, and none at all. Bit-by-bit comparison at each cclk rise separates the correct bit order from a reversed or dropped bit. The device model raises done after a chosen number of extra pulses: four, zero, or never. This tells a correct flush count apart from an early or late finish, and from the done-timeout path. Holding init low shows the init-timeout code and that no clock escapes. A source error after two of five bytes shows the early end of data with the byte in flight still completed.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POWER,
    ST_PROG,
    ST_WINIT,
    ST_DATA,
    ST_FLUSH,
    ST_OK,
    ST_ERR
  } ld_state_t;

  typedef enum logic [1:0] {
    EC_NONE = 2'b00,
    EC_INIT = 2'b01,
    EC_DONE = 2'b10
  } ld_err_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/cfg_tick_cnt.sv
module cfg_tick_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer #(
  parameter int unsigned HALF_CYCLES = 2,
  parameter int unsigned DW          = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [DW-1:0]               load_data,
  input  logic [$clog2(DW+1)-1:0]     load_bits,
  output logic                        cclk,
  output logic                        din,
  output logic                        active,
  output logic                        fin
);

  localparam int unsigned PW = (HALF_CYCLES < 2) ? 1 : $clog2(HALF_CYCLES);
  localparam int unsigned BW = $clog2(DW+1);

  logic          act_q, act_d;
  logic          hi_q, hi_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [BW-1:0] bits_q, bits_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          ph_last, last_bit;

  assign ph_last  = (ph_q == PW'(HALF_CYCLES-1));
  assign last_bit = (bits_q == BW'(1));
  assign fin      = act_q & hi_q & ph_last & last_bit;
  assign cclk     = hi_q;
  assign din      = sh_q[DW-1];
  assign active   = act_q;

  always_comb begin
    act_d  = act_q;
    hi_d   = hi_q;
    ph_d   = ph_q;
    bits_d = bits_q;
    sh_d   = sh_q;
    if (!act_q) begin
      if (load) begin
        act_d  = 1'b1;
        hi_d   = 1'b0;
        ph_d   = '0;
        bits_d = load_bits;
        sh_d   = load_data;
      end
    end else if (ph_last) begin
      ph_d = '0;
      if (!hi_q) begin
        hi_d = 1'b1;
      end else begin
        hi_d   = 1'b0;
        sh_d   = {sh_q[DW-2:0], 1'b0};
        bits_d = bits_q - 1'b1;
        if (last_bit) act_d = 1'b0;
      end
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hi_q   <= 1'b0;
      ph_q   <= '0;
      bits_q <= '0;
      sh_q   <= '0;
    end else begin
      act_q  <= act_d;
      hi_q   <= hi_d;
      ph_q   <= ph_d;
      bits_q <= bits_d;
      sh_q   <= sh_d;
    end
  end

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned LEN_W           = 16,
  parameter int unsigned SETTLE_CYCLES   = 1000,
  parameter int unsigned PROG_LOW_CYCLES = 1000,
  parameter int unsigned HALF_CYCLES     = 2,
  parameter int unsigned INIT_TIMEOUT    = 100000,
  parameter int unsigned DONE_TIMEOUT    = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  byte_len,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_error,
  input  logic              init_n,
  input  logic              done_in,
  output logic              pwr_en,
  output logic              prog_n,
  output logic              cclk,
  output logic              din,
  output logic              busy,
  output logic              ok,
  output logic              err,
  output logic [1:0]        err_code
);

  localparam int unsigned LIM_A = (SETTLE_CYCLES > PROG_LOW_CYCLES) ? SETTLE_CYCLES : PROG_LOW_CYCLES;
  localparam int unsigned LIM_B = (INIT_TIMEOUT > DONE_TIMEOUT) ? INIT_TIMEOUT : DONE_TIMEOUT;
  localparam int unsigned LIM   = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int unsigned CW    = $clog2(LIM+1);
  localparam int unsigned SBW   = $clog2(BYTE_W+1);

  ld_state_t          state_q, state_d;
  logic [LEN_W-1:0]   left_q, left_d;
  ld_err_t            code_q, code_d;
  logic [CW-1:0]      cnt;
  logic               cnt_clr, cnt_en;
  logic               ser_load, ser_act, ser_fin;
  logic [BYTE_W-1:0]  ser_data;
  logic [SBW-1:0]     ser_bits;

  cfg_tick_cnt #(.W(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  cfg_serializer #(.HALF_CYCLES(HALF_CYCLES), .DW(BYTE_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ser_load),
    .load_data (ser_data),
    .load_bits (ser_bits),
    .cclk      (cclk),
    .din       (din),
    .active    (ser_act),
    .fin       (ser_fin)
  );

  assign in_ready = (state_q == ST_DATA) && !ser_act && (left_q != '0) && !in_error;
  assign ser_data = (state_q == ST_DATA) ? in_data : '0;
  assign ser_bits = (state_q == ST_DATA) ? SBW'(BYTE_W) : SBW'(1);

  always_comb begin
    state_d  = state_q;
    left_d   = left_q;
    code_d   = code_q;
    cnt_en   = 1'b0;
    ser_load = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_OK, ST_ERR: begin
        if (start) begin
          state_d = ST_POWER;
          left_d  = byte_len;
          code_d  = EC_NONE;
        end
      end
      ST_POWER: begin
        cnt_en = 1'b1;
        if (cnt == CW'(SETTLE_CYCLES-1)) state_d = ST_PROG;
      end
      ST_PROG: begin
        cnt_en = 1'b1;
        if (cnt == CW'(PROG_LOW_CYCLES-1)) state_d = ST_WINIT;
      end
      ST_WINIT: begin
        cnt_en = 1'b1;
        if (init_n) begin
          state_d = ST_DATA;
        end else if (cnt == CW'(INIT_TIMEOUT-1)) begin
          state_d = ST_ERR;
          code_d  = EC_INIT;
        end
      end
      ST_DATA: begin
        if (in_valid && in_ready) begin
          ser_load = 1'b1;
          left_d   = left_q - 1'b1;
        end else if (!ser_act && ((left_q == '0) || in_error)) begin
          state_d = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        if (!ser_act) begin
          if (done_in) begin
            state_d = ST_OK;
          end else if (cnt == CW'(DONE_TIMEOUT)) begin
            state_d = ST_ERR;
            code_d  = EC_DONE;
          end else begin
            ser_load = 1'b1;
            cnt_en   = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      code_q  <= EC_NONE;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      code_q  <= code_d;
    end
  end

  assign pwr_en   = (state_q != ST_IDLE);
  assign prog_n   = (state_q != ST_PROG);
  assign busy     = (state_q != ST_IDLE) && (state_q != ST_OK) && (state_q != ST_ERR);
  assign ok       = (state_q == ST_OK);
  assign err      = (state_q == ST_ERR);
  assign err_code = code_q;

endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       done_in,
  input logic       pwr_en,
  input logic       prog_n,
  input logic       cclk,
  input logic       din,
  input logic       busy,
  input logic       ok,
  input logic       err,
  input logic [1:0] err_code
);

  // R10
  excl_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, ok, err}));

  // R2
  prog_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> pwr_en);

  // R2
  no_clk_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cclk |-> prog_n);

  // R4
  din_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(din));

  // R6
  ready_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && prog_n));

  // R10
  code_only_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'b00) |-> err);

  // R7
  ok_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> $past(done_in));

endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .done_in  (done_in),
  .pwr_en   (pwr_en),
  .prog_n   (prog_n),
  .cclk     (cclk),
  .din      (din),
  .busy     (busy),
  .ok       (ok),
  .err      (err),
  .err_code (err_code)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;

  localparam int SETTLE = 4;
  localparam int PLOW   = 6;
  localparam int HALF   = 2;
  localparam int INITTO = 40;
  localparam int DONETO = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] byte_len = '0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_error = 1'b0;
  logic        init_n = 1'b1;
  logic        done_in;
  logic        in_ready, pwr_en, prog_n, cclk, din, busy, ok, err;
  logic [1:0]  err_code;

  int n_chk = 0;
  int n_fail = 0;
  int hs = 0;
  int extra = 0;
  int pulses = 0;
  int done_thresh = 1 << 30;
  int init_delay = 3;
  bit init_never = 1'b0;
  int icnt = 0;
  int ready_cnt = 0;
  int hi_run = 0, lo_run = 1000, hi_bad = 0, lo_bad = 0;
  bit exp_q[$];

  always #10 clk = ~clk;

  serial_cfg_loader #(
    .LEN_W(16), .SETTLE_CYCLES(SETTLE), .PROG_LOW_CYCLES(PLOW),
    .HALF_CYCLES(HALF), .INIT_TIMEOUT(INITTO), .DONE_TIMEOUT(DONETO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_len(byte_len),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_error(in_error), .init_n(init_n), .done_in(done_in),
    .pwr_en(pwr_en), .prog_n(prog_n), .cclk(cclk), .din(din),
    .busy(busy), .ok(ok), .err(err), .err_code(err_code)
  );

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // device model: init and done lines
  always @(negedge clk) begin
    if (!prog_n) begin
      init_n <= 1'b0;
      icnt   <= 0;
    end else if (!init_never) begin
      if (icnt >= init_delay) init_n <= 1'b1;
      else                    icnt   <= icnt + 1;
    end
  end

  always @(posedge cclk or negedge prog_n) begin
    if (!prog_n) pulses <= 0;
    else         pulses <= pulses + 1;
  end

  assign done_in = prog_n && (pulses >= done_thresh);

  // scoreboard monitor: compare each bit at the cclk rise
  always @(posedge cclk) begin
    if (exp_q.size() > 0) begin
      automatic bit e = exp_q.pop_front();
      chk(din == e, "R4 bit order", int'(din), int'(e));
    end else begin
      extra++;
    end
  end

  // phase length and ready monitor
  always @(negedge clk) begin
    if (in_ready) ready_cnt++;
    if (cclk) begin
      if (hi_run == 0 && lo_run < HALF) lo_bad++;
      lo_run = 0;
      hi_run++;
    end else begin
      if (hi_run != 0) begin
        if (hi_run != HALF) hi_bad++;
        hi_run = 0;
      end
      lo_run++;
    end
  end

  // driver: offer one byte, push its bits on acceptance
  task automatic send_byte(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    for (int t = 0; t < 2000; t++) begin
      if (in_ready) begin
        for (int k = 7; k >= 0; k--) exp_q.push_back(b[k]);
        hs++;
        @(negedge clk);
        in_valid = 1'b0;
        return;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic run_cfg(input int nbytes, input int kx, input int idelay,
                         input bit inever, input int abort_at, input bit poke,
                         input bit exp_ok, input int exp_code, input int exp_extra,
                         input int exp_hs, input string tag);
    int s, p, w, rdy_snap;
    exp_q.delete();
    extra = 0;
    hs = 0;
    init_delay = idelay;
    init_never = inever;
    done_thresh = (kx < 0) ? (1 << 30) : (((abort_at >= 0) ? abort_at : nbytes) * 8 + kx);
    @(negedge clk);
    byte_len = 16'(nbytes);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(pwr_en == 1'b1, {tag, " R2 pwr_en"}, int'(pwr_en), 1);
    s = 0;
    while (prog_n && s < 1000) begin s++; @(negedge clk); end
    chk(s == SETTLE, {tag, " R2 settle"}, s, SETTLE);
    p = 0;
    while (!prog_n && p < 1000) begin p++; @(negedge clk); end
    chk(p == PLOW, {tag, " R2 prog low"}, p, PLOW);
    rdy_snap = ready_cnt;
    for (int i = 0; i < nbytes; i++) begin
      if (abort_at >= 0 && i == abort_at) begin
        in_error = 1'b1;
        @(negedge clk);
        rdy_snap = ready_cnt;
        break;
      end
      send_byte(8'((i * 8'h5B) ^ 8'hA5));
    end
    w = 0;
    while (busy && w < 5000) begin
      start = (poke && w == 3);
      @(negedge clk);
      w++;
    end
    start = 1'b0;
    if (abort_at >= 0) chk(ready_cnt == rdy_snap, {tag, " R9 ready after error"}, ready_cnt - rdy_snap, 0);
    in_error = 1'b0;
    chk(ok == exp_ok, {tag, " R7 ok"}, int'(ok), int'(exp_ok));
    chk(err == !exp_ok, {tag, " R8 err"}, int'(err), int'(!exp_ok));
    chk(int'(err_code) == exp_code, {tag, " R3 err_code"}, int'(err_code), exp_code);
    chk(extra == exp_extra, {tag, " R7 extra pulses"}, extra, exp_extra);
    chk(exp_q.size() == 0, {tag, " R4 bits left"}, exp_q.size(), 0);
    chk(hs == exp_hs, {tag, " R6 bytes taken"}, hs, exp_hs);
    repeat (4) @(negedge clk);
    chk(ok == exp_ok && !busy, {tag, " R10 hold"}, int'(ok), int'(exp_ok));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prog_n && !cclk && !din, "R1 pins", {prog_n, cclk, din}, 3'b100);
    chk(!pwr_en && !busy && !ok && !err && !in_ready, "R1 status", {pwr_en, busy, ok, err, in_ready}, 0);
    // nominal: 3 bytes, done after 4 extra pulses, start poked while busy (R10)
    run_cfg(3, 4, 5, 1'b0, -1, 1'b1, 1'b1, 0, 4, 3, "T2");
    // single byte, done right at end of data
    run_cfg(1, 0, 3, 1'b0, -1, 1'b0, 1'b1, 0, 0, 1, "T3");
    // R11 zero length
    ready_cnt = 0;
    run_cfg(0, 2, 3, 1'b0, -1, 1'b0, 1'b1, 0, 2, 0, "T4 R11");
    chk(ready_cnt == 0, "R11 ready never", ready_cnt, 0);
    // R3 init never rises
    run_cfg(0, 0, 3, 1'b1, -1, 1'b0, 1'b0, 1, 0, 0, "T5 R3");
    // R8 done never rises
    run_cfg(2, -1, 3, 1'b0, -1, 1'b0, 1'b0, 2, DONETO, 2, "T6 R8");
    // R9 source error after two of five bytes
    run_cfg(5, 3, 4, 1'b0, 2, 1'b0, 1'b1, 0, 3, 2, "T7 R9");
    chk(hi_bad == 0, "R5 high phase", hi_bad, 0);
    chk(lo_bad == 0, "R5 low phase", lo_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule